// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which of five interrupt request lines is serviced next. The lines rank in a fixed order. The highest-ranked line is a non-maskable trap. Below it are three fixed-vector lines, and each of these has its own mask bit. The lowest-ranked line is a general request whose branch target comes from an instruction that the core's bus supplies. A global enable, set and cleared by command pulses, gates every line except the trap.

When a request wins, the block tells the core to save the program counter and branch, using a one-cycle acknowledge pulse. The same cycle carries the 16-bit target address. A fixed-vector winner is granted straight away. For a general request the block first asks for instruction bytes on `ext_fetch` and decodes them. A restart opcode of the form `11NNN111` gives the target N×8. The call opcode `0xCD` is followed by a low address byte and then a high address byte. Any other opcode is dropped.

The sequencer has five states. IDLE waits for a winner. GRANT is the acknowledge cycle. FETCH_OP waits for the opcode byte. FETCH_LO and FETCH_HI wait for the two call address bytes. The transitions are:
- IDLE→GRANT when a trap or fixed-vector line wins.
- IDLE→FETCH_OP when the general line wins.
- FETCH_OP→GRANT on a restart opcode.
- FETCH_OP→FETCH_LO on the call opcode.
- FETCH_OP→IDLE on any other opcode.
- FETCH_LO→FETCH_HI when the low byte arrives.
- FETCH_HI→GRANT when the high byte arrives.
- GRANT→IDLE always.

Top module: `irq_vector_ctrl`

## Requirements
- R1: If several lines are eligible in the same cycle, the winner is chosen in this order, highest first: trap `irq_req[4]`, `irq_req[3]`, `irq_req[2]`, `irq_req[1]`, general `irq_req[0]`.
- R2: The trap line vectors to 0x0024. Neither the global enable nor the mask bits affect it.
- R3: `irq_req[1]` vectors to 0x002C, `irq_req[2]` to 0x0034 and `irq_req[3]` to 0x003C.
- R4: Reset clears the global enable. A `cmd_en` pulse sets it and a `cmd_dis` pulse clears it; when both pulse in the same cycle, the enable is cleared. While the enable is clear, no line other than the trap is accepted.
- R5: A `cmd_mask_we` pulse loads `cmd_mask_bits`. Bit 0 masks `irq_req[1]`, bit 1 masks `irq_req[2]` and bit 2 masks `irq_req[3]`, and 1 means masked. Reset sets all three bits.
- R6: When the general line wins, the block raises `ext_fetch` until it consumes a byte (`ext_byte_vld` high). An opcode `11NNN111` gives the vector N×8.
- R7: The opcode 0xCD makes the block consume two more bytes, low byte first, and the vector is {high, low}. Gaps in `ext_byte_vld` only stretch the wait.
- R8: Any other opcode ends the sequence with no acknowledge, and the global enable stays cleared.
- R9: An accepted fixed-vector or trap request gives `irq_ack` high for exactly one cycle, in the cycle after the one in which the request was eligible. `push_pc` is high and `irq_vector` is valid in that same cycle.
- R10: Accepting any maskable line clears the global enable. This clear takes precedence over a `cmd_en` pulse in the same cycle.
- R11: A line that is masked or disabled is accepted later, once it becomes eligible, as long as it is still held high.
- R12: The trap is accepted once for each assertion of its line. It is not accepted again until the line has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 5 | Level request lines, bit 4 trap down to bit 0 general |
| cmd_en | input | 1 | Global enable set pulse |
| cmd_dis | input | 1 | Global enable clear pulse |
| cmd_mask_we | input | 1 | Load pulse for the individual mask bits |
| cmd_mask_bits | input | 3 | New mask bits, 1 = masked |
| ext_byte_vld | input | 1 | An instruction byte is present on `ext_byte` |
| ext_byte | input | 8 | Instruction byte for the general request |
| ext_fetch | output | 1 | The block is waiting for an instruction byte |
| irq_ack | output | 1 | Acceptance pulse |
| push_pc | output | 1 | The core should save the program counter now |
| irq_vector | output | 16 | Branch target, valid while `irq_ack` is high |

## Verification
The hardest situation to reach from the ports is the single cycle in which an acceptance and an enable command collide. Reaching it needs the enable already set and the request and the `cmd_en` pulse driven on the same clock edge. The bench sets this up and then shows that the enable came out cleared, by holding a second unmasked line that must go unanswered. The unsupported-opcode path is checked the same way: it has no acknowledge of its own, so its effect is made visible through a later request. A held trap line has to stay high for many cycles to show that a level request alone cannot trigger a repeat.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRANT,
        ST_FETCH_OP,
        ST_FETCH_LO,
        ST_FETCH_HI
    } seq_state_e;

    localparam logic [7:0] OPC_CALL = 8'hCD;

    // restart opcode pattern: two ones, three code bits, three ones
    function automatic logic is_restart(input logic [7:0] opc);
        return (opc[7:6] == 2'b11) && (opc[2:0] == 3'b111);
    endfunction

endpackage

// File: rtl/irq_gate_regs.sv
module irq_gate_regs #(
    parameter int NUM_FIXED = 3,
    localparam int NUM_SRC  = NUM_FIXED + 2,
    localparam int NMI_IDX  = NUM_SRC - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   req,
    input  logic                 cmd_en,
    input  logic                 cmd_dis,
    input  logic                 mask_we,
    input  logic [NUM_FIXED-1:0] mask_bits,
    input  logic                 accept_mask,
    input  logic                 accept_nmi,
    output logic [NUM_SRC-1:0]   elig,
    output logic                 glob_en,
    output logic [NUM_FIXED-1:0] mask_q
);

    logic nmi_armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
        end else if (accept_mask || cmd_dis) begin
            glob_en <= 1'b0;
        end else if (cmd_en) begin
            glob_en <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= mask_bits;
        end
    end

    // trap re-arms only once its line has been seen low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_armed <= 1'b1;
        end else if (accept_nmi) begin
            nmi_armed <= 1'b0;
        end else if (!req[NMI_IDX]) begin
            nmi_armed <= 1'b1;
        end
    end

    assign elig[0]       = req[0] & glob_en;
    assign elig[NMI_IDX] = req[NMI_IDX] & nmi_armed;

    for (genvar g = 1; g <= NUM_FIXED; g++) begin : g_fixed_gate
        assign elig[g] = req[g] & glob_en & ~mask_q[g-1];
    end

    assert_en_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept_mask |=> !glob_en);

    assert_nmi_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        accept_nmi |=> !nmi_armed);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 5
) (
    input  logic [NUM_SRC-1:0] elig,
    output logic [NUM_SRC-1:0] grant,
    output logic               any
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pick
        if (i == NUM_SRC - 1) begin : g_top
            assign grant[i] = elig[i];
        end else begin : g_lower
            assign grant[i] = elig[i] & ~(|elig[NUM_SRC-1:i+1]);
        end
    end

    assign any = |elig;

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_ctrl_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              NUM_FIXED = 3,
    parameter logic [15:0]     TRAP_BASE = 16'h0024,
    parameter int              VEC_STEP  = 8,
    localparam int             NUM_SRC   = NUM_FIXED + 2,
    localparam int             NMI_IDX   = NUM_SRC - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] grant,
    input  logic               any,
    input  logic               ext_byte_vld,
    input  logic [7:0]         ext_byte,
    output logic               accept_mask,
    output logic               accept_nmi,
    output logic               ext_fetch,
    output logic               irq_ack,
    output logic               push_pc,
    output logic [ADDR_W-1:0]  irq_vector
);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] vec_q, vec_d;
    logic [7:0]        lo_q, lo_d;
    logic [ADDR_W-1:0] fix_vec;

    always_comb begin
        fix_vec = '0;
        for (int j = 1; j <= NUM_FIXED; j++) begin
            if (grant[j]) begin
                fix_vec = ADDR_W'(TRAP_BASE) + ADDR_W'(VEC_STEP * j);
            end
        end
        if (grant[NMI_IDX]) begin
            fix_vec = ADDR_W'(TRAP_BASE);
        end
    end

    always_comb begin
        state_d     = state_q;
        vec_d       = vec_q;
        lo_d        = lo_q;
        accept_mask = 1'b0;
        accept_nmi  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any) begin
                    accept_nmi  = grant[NMI_IDX];
                    accept_mask = ~grant[NMI_IDX];
                    if (grant[0]) begin
                        state_d = ST_FETCH_OP;
                    end else begin
                        state_d = ST_GRANT;
                        vec_d   = fix_vec;
                    end
                end
            end
            ST_FETCH_OP: begin
                if (ext_byte_vld) begin
                    if (is_restart(ext_byte)) begin
                        state_d = ST_GRANT;
                        vec_d   = ADDR_W'({ext_byte[5:3], 3'b000});
                    end else if (ext_byte == OPC_CALL) begin
                        state_d = ST_FETCH_LO;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_FETCH_LO: begin
                if (ext_byte_vld) begin
                    lo_d    = ext_byte;
                    state_d = ST_FETCH_HI;
                end
            end
            ST_FETCH_HI: begin
                if (ext_byte_vld) begin
                    vec_d   = ADDR_W'({ext_byte, lo_q});
                    state_d = ST_GRANT;
                end
            end
            ST_GRANT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
            lo_q    <= lo_d;
        end
    end

    always_comb begin
        irq_ack    = 1'b0;
        push_pc    = 1'b0;
        ext_fetch  = 1'b0;
        irq_vector = '0;
        unique case (state_q)
            ST_GRANT: begin
                irq_ack    = 1'b1;
                push_pc    = 1'b1;
                irq_vector = vec_q;
            end
            ST_FETCH_OP, ST_FETCH_LO, ST_FETCH_HI: begin
                ext_fetch = 1'b1;
            end
            default: begin
                irq_ack = 1'b0;
            end
        endcase
    end

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    assert_no_fetch_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fetch |-> !irq_ack);

    assert_trap_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && grant[NMI_IDX]) |=> (irq_vector == ADDR_W'(TRAP_BASE)));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int          ADDR_W    = 16,
    parameter int          NUM_FIXED = 3,
    parameter logic [15:0] TRAP_BASE = 16'h0024,
    parameter int          VEC_STEP  = 8,
    localparam int         NUM_SRC   = NUM_FIXED + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_req,
    input  logic                 cmd_en,
    input  logic                 cmd_dis,
    input  logic                 cmd_mask_we,
    input  logic [NUM_FIXED-1:0] cmd_mask_bits,
    input  logic                 ext_byte_vld,
    input  logic [7:0]           ext_byte,
    output logic                 ext_fetch,
    output logic                 irq_ack,
    output logic                 push_pc,
    output logic [ADDR_W-1:0]    irq_vector
);

    logic [NUM_SRC-1:0]   elig;
    logic [NUM_SRC-1:0]   grant;
    logic                 any;
    logic                 glob_en;
    logic [NUM_FIXED-1:0] mask_q;
    logic                 accept_mask;
    logic                 accept_nmi;

    irq_gate_regs #(.NUM_FIXED(NUM_FIXED)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (irq_req),
        .cmd_en      (cmd_en),
        .cmd_dis     (cmd_dis),
        .mask_we     (cmd_mask_we),
        .mask_bits   (cmd_mask_bits),
        .accept_mask (accept_mask),
        .accept_nmi  (accept_nmi),
        .elig        (elig),
        .glob_en     (glob_en),
        .mask_q      (mask_q)
    );

    irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .elig  (elig),
        .grant (grant),
        .any   (any)
    );

    irq_seq_fsm #(
        .ADDR_W    (ADDR_W),
        .NUM_FIXED (NUM_FIXED),
        .TRAP_BASE (TRAP_BASE),
        .VEC_STEP  (VEC_STEP)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant        (grant),
        .any          (any),
        .ext_byte_vld (ext_byte_vld),
        .ext_byte     (ext_byte),
        .accept_mask  (accept_mask),
        .accept_nmi   (accept_nmi),
        .ext_fetch    (ext_fetch),
        .irq_ack      (irq_ack),
        .push_pc      (push_pc),
        .irq_vector   (irq_vector)
    );

    assert_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !(|grant[NUM_SRC-2:0]));

    assert_mask_respected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant[NUM_FIXED:1] & mask_q)) == 1'b0);

    assert_single_winner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any == (|grant)));

endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  irq_req = '0;
    logic        cmd_en = 1'b0;
    logic        cmd_dis = 1'b0;
    logic        cmd_mask_we = 1'b0;
    logic [2:0]  cmd_mask_bits = '0;
    logic        ext_byte_vld = 1'b0;
    logic [7:0]  ext_byte = '0;
    logic        ext_fetch;
    logic        irq_ack;
    logic        push_pc;
    logic [15:0] irq_vector;

    int n_chk  = 0;
    int n_fail = 0;
    int ack_cnt = 0;
    int cyc = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    irq_vector_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_req       (irq_req),
        .cmd_en        (cmd_en),
        .cmd_dis       (cmd_dis),
        .cmd_mask_we   (cmd_mask_we),
        .cmd_mask_bits (cmd_mask_bits),
        .ext_byte_vld  (ext_byte_vld),
        .ext_byte      (ext_byte),
        .ext_fetch     (ext_fetch),
        .irq_ack       (irq_ack),
        .push_pc       (push_pc),
        .irq_vector    (irq_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every acknowledge
    always @(negedge clk) begin
        if (rst_n && irq_ack) begin
            ack_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected ack", {16'h0, irq_vector}, 32'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(irq_vector == e, t, {16'h0, irq_vector}, {16'h0, e});
                check(push_pc == 1'b1, "R9 push_pc with ack", {31'h0, push_pc}, 32'h1);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic expect_vec(input logic [15:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic wait_ack(input string t);
        int k;
        for (k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            if (exp_q.size() == 0) break;
        end
        check(exp_q.size() == 0, t, exp_q.size(), 0);
    endtask

    task automatic quiet(input int n, input string t);
        int c0;
        c0 = ack_cnt;
        repeat (n) @(negedge clk);
        #1;
        check(ack_cnt == c0, t, ack_cnt, c0);
    endtask

    task automatic pulse_en();
        @(negedge clk); cmd_en = 1'b1;
        @(negedge clk); cmd_en = 1'b0;
    endtask

    task automatic load_mask(input logic [2:0] m);
        @(negedge clk); cmd_mask_we = 1'b1; cmd_mask_bits = m;
        @(negedge clk); cmd_mask_we = 1'b0;
    endtask

    task automatic feed_byte(input logic [7:0] b);
        @(negedge clk);
        while (!ext_fetch) @(negedge clk);
        ext_byte_vld = 1'b1; ext_byte = b;
        @(negedge clk);
        ext_byte_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(irq_ack == 1'b0 && ext_fetch == 1'b0, "R4 reset outputs idle", {irq_ack, ext_fetch}, 0);

        // R4: after reset the enable is clear, line 0 ignored
        @(negedge clk); irq_req[0] = 1'b1;
        quiet(6, "R4 general ignored after reset");
        check(ext_fetch == 1'b0, "R4 no fetch while disabled", ext_fetch, 0);
        irq_req[0] = 1'b0;

        // R2/R9: trap with enable clear and all masked, exact latency
        @(negedge clk); irq_req[4] = 1'b1; expect_vec(16'h0024, "R2 trap vector");
        @(negedge clk); #1;
        check(exp_q.size() == 0, "R9 ack one cycle after request", exp_q.size(), 0);
        @(negedge clk); #1;
        check(irq_ack == 1'b0, "R9 ack lasts one cycle", irq_ack, 0);
        // R12: held trap is not re-accepted
        quiet(10, "R12 held trap accepted once");
        irq_req[4] = 1'b0;
        @(negedge clk); irq_req[4] = 1'b1; expect_vec(16'h0024, "R12 trap re-accepted after drop");
        wait_ack("R12 second trap ack");
        irq_req[4] = 1'b0;

        // R5/R11: enabled but masked line waits, then fires when unmasked
        pulse_en();
        @(negedge clk); irq_req[1] = 1'b1;
        quiet(8, "R5 masked line ignored at reset mask");
        expect_vec(16'h002C, "R3 R11 line1 vector after unmask");
        load_mask(3'b110);
        wait_ack("R11 pending line accepted");
        irq_req[1] = 1'b0;

        // R10: enable cleared by acceptance; R3 line2 vector
        load_mask(3'b000);
        @(negedge clk); irq_req[2] = 1'b1;
        quiet(6, "R10 enable cleared after accept");
        expect_vec(16'h0034, "R3 line2 vector");
        pulse_en();
        wait_ack("R11 line2 after enable");
        irq_req[2] = 1'b0;

        // R1: priority among fixed lines
        @(negedge clk); irq_req[3:1] = 3'b111;
        expect_vec(16'h003C, "R1 R3 line3 wins");
        pulse_en();
        wait_ack("R1 first winner");
        irq_req[3] = 1'b0;
        expect_vec(16'h0034, "R1 line2 next");
        pulse_en();
        wait_ack("R1 second winner");
        irq_req[2] = 1'b0;
        expect_vec(16'h002C, "R1 line1 last");
        pulse_en();
        wait_ack("R1 third winner");
        irq_req[1] = 1'b0;

        // R1: trap beats everything
        pulse_en();
        @(negedge clk); irq_req = 5'b11111;
        expect_vec(16'h0024, "R1 trap over all");
        wait_ack("R1 trap first");
        irq_req[4] = 1'b0;
        expect_vec(16'h003C, "R1 line3 after trap");
        wait_ack("R1 line3 after trap ack");
        irq_req = '0;

        // R5: mask bit 2 only masks line3
        load_mask(3'b100);
        pulse_en();
        @(negedge clk); irq_req[3] = 1'b1;
        quiet(5, "R5 line3 masked by bit2");
        irq_req[3] = 1'b0;
        load_mask(3'b000);

        // R4: disable wins over simultaneous enable
        @(negedge clk); cmd_en = 1'b1; cmd_dis = 1'b1;
        @(negedge clk); cmd_en = 1'b0; cmd_dis = 1'b0;
        irq_req[1] = 1'b1;
        quiet(5, "R4 disable wins over enable");
        irq_req[1] = 1'b0;

        // R10: acceptance clear beats enable in same cycle
        pulse_en();
        @(negedge clk); irq_req[2] = 1'b1; cmd_en = 1'b1;
        expect_vec(16'h0034, "R10 collide accept");
        @(negedge clk); cmd_en = 1'b0;
        wait_ack("R10 collide ack");
        irq_req[2] = 1'b0;
        @(negedge clk); irq_req[1] = 1'b1;
        quiet(6, "R10 accept clear beats enable");
        expect_vec(16'h002C, "R10 line1 after re-enable");
        pulse_en();
        wait_ack("R10 line1 ack");
        irq_req[1] = 1'b0;

        // R6: restart opcodes through the general line
        pulse_en();
        @(negedge clk); irq_req[0] = 1'b1;
        expect_vec(16'h0028, "R6 restart code 5");
        feed_byte(8'hEF);
        irq_req[0] = 1'b0;
        wait_ack("R6 restart 5 ack");
        pulse_en();
        @(negedge clk); irq_req[0] = 1'b1;
        expect_vec(16'h0038, "R6 restart code 7");
        feed_byte(8'hFF);
        irq_req[0] = 1'b0;
        wait_ack("R6 restart 7 ack");
        pulse_en();
        @(negedge clk); irq_req[0] = 1'b1;
        expect_vec(16'h0000, "R6 restart code 0");
        feed_byte(8'hC7);
        irq_req[0] = 1'b0;
        wait_ack("R6 restart 0 ack");

        // R7: call with a gap before the high byte
        pulse_en();
        @(negedge clk); irq_req[0] = 1'b1;
        expect_vec(16'h1234, "R7 call target");
        feed_byte(8'hCD);
        irq_req[0] = 1'b0;
        feed_byte(8'h34);
        repeat (3) @(negedge clk);
        #1;
        check(ext_fetch == 1'b1 && ack_cnt >= 0 && exp_q.size() == 1, "R7 waits through gap", {31'h0, ext_fetch}, 1);
        feed_byte(8'h12);
        wait_ack("R7 call ack");

        // R8: unsupported opcode, no ack, enable left clear
        pulse_en();
        @(negedge clk); irq_req[0] = 1'b1;
        feed_byte(8'h00);
        irq_req[0] = 1'b0;
        quiet(4, "R8 no ack on bad opcode");
        check(ext_fetch == 1'b0, "R8 fetch ends", ext_fetch, 0);
        @(negedge clk); irq_req[1] = 1'b1;
        quiet(5, "R8 enable stays clear");
        expect_vec(16'h002C, "R8 line1 after re-enable");
        pulse_en();
        wait_ack("R8 line1 ack");
        irq_req[1] = 1'b0;

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule